// File: doc/BRIEF.md
# Berlekamp-Massey Key Equation Solver

This block takes the 64 syndromes of a received word of a t = 32 Reed-Solomon code over GF(2^8) and finds the error locator polynomial Lambda(x) and the error evaluator polynomial Omega(x). A start strobe latches the syndrome vector. A sequential lambda stage then runs 2t iterations of the inversion-based Berlekamp-Massey recursion. It keeps a scaled correction polynomial and divides by the discrepancy through a constant inverse table. An omega stage follows. It forms [1 + S(x)] * Lambda(x) truncated above x^64, one coefficient per cycle.

One bank of t+1 GF multipliers does all the work. Its operands are switched between the discrepancy sum, the locator update, the correction rescale and the omega convolution. A single-cycle done strobe marks valid results. The results hold until the next accepted start. A failure flag marks an uncorrectable outcome. When all syndromes are zero, both stages are skipped.

Top module: `bm_key_solver`

## Requirements
- R1: The field is GF(2^8) with primitive polynomial x^8+x^4+x^3+x^2+1 and alpha = 0x02. Syndrome S_m (m = 1..64) sits at syn_i[8(m-1)+7 : 8(m-1)]. Coefficient i of lambda_o and of omega_o sits at bits [8i+7 : 8i].
- R2: A start accepted with all syndromes zero raises done_o on the next cycle, with Lambda = 1, Omega = 1, len_o = 0 and fail_o = 0.
- R3: Let v <= 32 errors with values Y_j sit at distinct positions p_j, so that S_m = sum Y_j * alpha^(m*p_j). Then at done, Lambda(x) = prod(1 + alpha^(p_j) x) and len_o = v. Coefficient 0 of Lambda is 1 at all times.
- R4: At done, Omega(x) equals [1 + S(x)] * Lambda(x) mod x^65, where S(x) = sum over m of S_m x^m. The output has 65 coefficients.
- R5: At done, fail_o is 1 exactly when len_o exceeds 32 or exceeds the degree of Lambda(x).
- R6: A start strobe that arrives while a solve is in progress is ignored, and the running solve completes on the syndromes it latched.
- R7: done_o is high for one cycle per solve. While the block is idle and no start is accepted, lambda_o, omega_o, len_o and fail_o keep their values.
- R8: A start strobe in the same cycle as done_o is accepted and begins a new solve.
- R9: After reset, done_o = 0, Lambda = 1, Omega = 0, len_o = 0 and fail_o = 0.
- R10: For nonzero syndromes, done_o rises between 193 and 257 cycles after the accepting clock edge. Each iteration takes 2 cycles, plus 1 when the length grows, and the omega stage takes 65 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| syn_i | input | 512 | Syndromes S_1..S_64, 8 bits each |
| done_o | output | 1 | One-cycle result strobe |
| lambda_o | output | 264 | Error locator coefficients 0..32 |
| omega_o | output | 520 | Error evaluator coefficients 0..64 |
| len_o | output | 7 | Final register length L |
| fail_o | output | 1 | Uncorrectable flag |

## Verification
The one collision the controller must resolve is a new start landing in the very cycle that the previous solve reports done. The idle state and the result strobe coincide there. The bench raises start, with zero syndromes, on the sample where it first sees done_o. It then expects a second done one cycle later, carrying the trivial result. It also checks that the first result was intact when sampled. A start pulsed mid-solve, with different syndromes, is judged by comparing the final polynomials against the first pattern only.

// File: rtl/bm_gf_pkg.sv
package bm_gf_pkg;

  localparam int GF_W = 8;
  localparam logic [GF_W-1:0] GF_POLY = 8'h1D;  // x^8 term implied

  typedef logic [GF_W-1:0] sym_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DISC,
    PH_UPD,
    PH_SCALE,
    PH_OMEGA
  } bm_phase_e;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_W; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[GF_W-2:0], 1'b0} ^ (sh[GF_W-1] ? GF_POLY : '0);
    end
    return acc;
  endfunction

  // a^(2^W - 2) by square and multiply
  function automatic sym_t gf_inv(sym_t a);
    sym_t r;
    sym_t base;
    int   e;
    r    = GF_W'(1);
    base = a;
    e    = (1 << GF_W) - 2;
    for (int i = 0; i < GF_W; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

endpackage

// File: rtl/gf_mul_bank.sv
module gf_mul_bank import bm_gf_pkg::*; #(
  parameter int LANES = 33
) (
  input  logic [LANES-1:0][GF_W-1:0] a_i,
  input  logic [LANES-1:0][GF_W-1:0] b_i,
  output logic [LANES-1:0][GF_W-1:0] p_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign p_o[g] = gf_mul(a_i[g], b_i[g]);
  end

endmodule

// File: rtl/gf_inv_rom.sv
module gf_inv_rom import bm_gf_pkg::*; (
  input  logic [GF_W-1:0] addr_i,
  output logic [GF_W-1:0] data_o
);

  localparam int NENT = 1 << GF_W;

  logic [GF_W-1:0] tab [NENT];

  // entry 0 has no inverse and is never addressed
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    localparam logic [GF_W-1:0] INV_VAL = gf_inv(GF_W'(g));
    assign tab[g] = INV_VAL;
  end

  assign data_o = tab[addr_i];

endmodule

// File: rtl/bm_seq_ctrl.sv
module bm_seq_ctrl import bm_gf_pkg::*; #(
  parameter int NSYN = 64,
  parameter int CW   = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          syn_zero_i,
  input  logic          delta_nz_i,
  input  logic          grow_i,
  output bm_phase_e     phase_o,
  output logic [CW-1:0] iter_o,
  output logic [CW-1:0] oidx_o,
  output logic          accept_o,
  output logic          done_o
);

  bm_phase_e     ph_q;
  logic [CW-1:0] k_q, j_q;
  logic          done_q;
  logic          last_iter;

  assign accept_o  = (ph_q == PH_IDLE) && start_i;
  assign last_iter = (k_q == CW'(NSYN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      k_q    <= '0;
      j_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            if (syn_zero_i) begin
              done_q <= 1'b1;
            end else begin
              ph_q <= PH_DISC;
              k_q  <= CW'(1);
            end
          end
        end
        PH_DISC: ph_q <= PH_UPD;
        PH_UPD, PH_SCALE: begin
          if (ph_q == PH_UPD && delta_nz_i && grow_i) begin
            ph_q <= PH_SCALE;
          end else if (last_iter) begin
            ph_q <= PH_OMEGA;
            j_q  <= '0;
          end else begin
            ph_q <= PH_DISC;
            k_q  <= k_q + 1'b1;
          end
        end
        PH_OMEGA: begin
          if (j_q == CW'(NSYN)) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = ph_q;
  assign iter_o  = k_q;
  assign oidx_o  = j_q;
  assign done_o  = done_q;

  p_iter_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q inside {PH_DISC, PH_UPD, PH_SCALE}) |-> (k_q >= CW'(1) && k_q <= CW'(NSYN)));

  p_scale_after_upd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SCALE) |-> ($past(ph_q) == PH_UPD));

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (ph_q == PH_IDLE));

  p_omega_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ph_q == PH_OMEGA)) |-> (j_q == '0));

endmodule

// File: rtl/bm_key_solver.sv
module bm_key_solver import bm_gf_pkg::*; #(
  parameter int T_CAP = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [2*T_CAP*GF_W-1:0]            syn_i,
  output logic                               done_o,
  output logic [(T_CAP+1)*GF_W-1:0]          lambda_o,
  output logic [(2*T_CAP+1)*GF_W-1:0]        omega_o,
  output logic [$clog2(2*T_CAP+1)-1:0]       len_o,
  output logic                               fail_o
);

  localparam int NSYN = 2 * T_CAP;
  localparam int NLAM = T_CAP + 1;
  localparam int NOMG = NSYN + 1;
  localparam int CW   = $clog2(NSYN + 1);
  localparam int SIW  = $clog2(NSYN);

  logic [NSYN-1:0][GF_W-1:0] syn_q;
  logic [NLAM-1:0][GF_W-1:0] lam_q, tpl_q;
  logic [NLAM-1:0][GF_W-1:0] mul_a, mul_b, mul_p;
  logic [NOMG-1:0][GF_W-1:0] omg_q;
  logic [CW-1:0]             len_q, k_w, j_w, lam_deg;
  sym_t                      delta_q, inv_w, psum;
  logic                      fail_q;
  bm_phase_e                 phase;
  logic                      accept, done_w, syn_zero, delta_nz, grow;

  assign syn_zero = (syn_i == '0);
  assign delta_nz = (delta_q != '0);
  assign grow     = ({1'b0, len_q} << 1) < {1'b0, k_w};

  bm_seq_ctrl #(.NSYN(NSYN), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .syn_zero_i (syn_zero),
    .delta_nz_i (delta_nz),
    .grow_i     (grow),
    .phase_o    (phase),
    .iter_o     (k_w),
    .oidx_o     (j_w),
    .accept_o   (accept),
    .done_o     (done_w)
  );

  gf_inv_rom u_inv (
    .addr_i (delta_q),
    .data_o (inv_w)
  );

  gf_mul_bank #(.LANES(NLAM)) u_mul (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (mul_p)
  );

  // operand select for the shared multiplier bank
  always_comb begin
    for (int i = 0; i < NLAM; i++) begin
      int d;
      mul_a[i] = '0;
      mul_b[i] = '0;
      d = 0;
      unique case (phase)
        PH_DISC: begin
          d        = int'(k_w) - i;
          mul_a[i] = lam_q[i];
          if (d >= 1 && d <= NSYN) mul_b[i] = syn_q[SIW'(d - 1)];
        end
        PH_UPD: begin
          mul_a[i] = delta_q;
          mul_b[i] = tpl_q[i];
        end
        PH_SCALE: begin
          mul_a[i] = lam_q[i];
          mul_b[i] = inv_w;
        end
        PH_OMEGA: begin
          d        = int'(j_w) - i;
          mul_a[i] = lam_q[i];
          if (d == 0)                    mul_b[i] = GF_W'(1);
          else if (d >= 1 && d <= NSYN)  mul_b[i] = syn_q[SIW'(d - 1)];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    psum = '0;
    for (int i = 0; i < NLAM; i++) psum ^= mul_p[i];
  end

  always_comb begin
    lam_deg = '0;
    for (int i = 0; i < NLAM; i++) begin
      if (lam_q[i] != '0) lam_deg = CW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      syn_q   <= '0;
      lam_q   <= (NLAM*GF_W)'(1);
      tpl_q   <= '0;
      omg_q   <= '0;
      len_q   <= '0;
      delta_q <= '0;
      fail_q  <= 1'b0;
    end else if (accept) begin
      syn_q   <= syn_i;
      lam_q   <= (NLAM*GF_W)'(1);
      tpl_q   <= (NLAM*GF_W)'(1) << GF_W;  // T(x) = x
      len_q   <= '0;
      delta_q <= '0;
      fail_q  <= 1'b0;
      omg_q   <= syn_zero ? (NOMG*GF_W)'(1) : '0;
    end else begin
      unique case (phase)
        PH_DISC: delta_q <= psum;
        PH_UPD: begin
          if (delta_nz) lam_q <= lam_q ^ mul_p;
          if (delta_nz && grow) len_q <= k_w - len_q;
          else                  tpl_q <= tpl_q << GF_W;
        end
        // T = x * (T_old + Lambda_new / delta) == x * Lambda_old / delta
        PH_SCALE: tpl_q <= (tpl_q ^ mul_p) << GF_W;
        PH_OMEGA: begin
          omg_q[j_w] <= psum;
          if (j_w == CW'(NSYN))
            fail_q <= (len_q > CW'(T_CAP)) || (len_q > lam_deg);
        end
        default: ;
      endcase
    end
  end

  assign done_o   = done_w;
  assign lambda_o = lam_q;
  assign omega_o  = omg_q;
  assign len_o    = len_q;
  assign fail_o   = fail_q;

  p_lam_const_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lam_q[0] == GF_W'(1));

  p_scale_nz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SCALE) |-> (delta_q != '0));

  p_inv_ok_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SCALE) |-> (gf_mul(delta_q, inv_w) == GF_W'(1)));

  p_len_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= CW'(NSYN));

  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE && start_i) |=> $stable(syn_q));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE && !start_i) |=>
      ($stable(lam_q) && $stable(omg_q) && $stable(len_q) && $stable(fail_q)));

  p_fail_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_w && len_q > CW'(T_CAP)) |-> fail_q);

endmodule

// File: tb/bm_key_solver_bench.sv
`timescale 1ns/1ps
module bm_key_solver_bench;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [511:0] syn_i = '0;
  logic         done_o;
  logic [263:0] lambda_o;
  logic [519:0] omega_o;
  logic [6:0]   len_o;
  logic         fail_o;

  int n_chk = 0;
  int n_fail = 0;
  int tick = 0;

  int         gexp [255];
  int         glog [256];
  logic [7:0] syn  [65];
  logic [7:0] elam [33];
  logic [7:0] eomg [65];
  int         epos [64];
  logic [7:0] eval [64];
  int         ne;

  always #2.5 clk = ~clk;

  bm_key_solver u_bm_key_solver (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .syn_i    (syn_i),
    .done_o   (done_o),
    .lambda_o (lambda_o),
    .omega_o  (omega_o),
    .len_o    (len_o),
    .fail_o   (fail_o)
  );

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return 8'(gexp[(glog[a] + glog[b]) % 255]);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [575:0] act, input logic [575:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] pack_syn();
    logic [511:0] v;
    for (int m = 1; m <= 64; m++) v[8*(m-1) +: 8] = syn[m];
    return v;
  endfunction

  function automatic logic [263:0] pack_lam();
    logic [263:0] v;
    for (int i = 0; i < 33; i++) v[8*i +: 8] = elam[i];
    return v;
  endfunction

  function automatic logic [519:0] pack_omg();
    logic [519:0] v;
    for (int i = 0; i < 65; i++) v[8*i +: 8] = eomg[i];
    return v;
  endfunction

  task automatic clear_syn();
    for (int m = 0; m < 65; m++) syn[m] = 8'h00;
  endtask

  // R1: S_m = sum Y * alpha^(m*p)
  task automatic calc_syn();
    clear_syn();
    for (int m = 1; m <= 64; m++)
      for (int e = 0; e < ne; e++)
        syn[m] ^= gmul(eval[e], 8'(gexp[(m * epos[e]) % 255]));
  endtask

  task automatic calc_lam();
    for (int i = 0; i < 33; i++) elam[i] = 8'h00;
    elam[0] = 8'h01;
    for (int e = 0; e < ne; e++) begin
      logic [7:0] x;
      x = 8'(gexp[epos[e] % 255]);
      for (int i = 32; i >= 1; i--) elam[i] ^= gmul(x, elam[i-1]);
    end
  endtask

  task automatic calc_omg();
    for (int j = 0; j < 65; j++) begin
      eomg[j] = 8'h00;
      for (int i = 0; i <= j && i < 33; i++)
        eomg[j] ^= gmul(elam[i], (j - i == 0) ? 8'h01 : syn[j-i]);
    end
  endtask

  task automatic launch_wait(output int cyc);
    @(negedge clk);
    syn_i   = pack_syn();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_full(input string tag, input int cyc, input logic exp_fail);
    chk("R3", {tag, " lambda"}, lambda_o, pack_lam());
    chk("R4", {tag, " omega"}, omega_o, pack_omg());
    chk("R3", {tag, " len"}, len_o, 7'(ne));
    chk("R5", {tag, " fail"}, fail_o, exp_fail);
    chk("R10", {tag, " latency"}, (cyc >= 193 && cyc <= 257), 1'b1);
  endtask

  task automatic t_reset();
    chk("R9", "reset done", done_o, 1'b0);
    chk("R9", "reset lambda", lambda_o, 264'h1);
    chk("R9", "reset omega", omega_o, 520'h0);
    chk("R9", "reset len", len_o, 7'd0);
    chk("R9", "reset fail", fail_o, 1'b0);
  endtask

  task automatic t_zero();
    int cyc;
    clear_syn();
    launch_wait(cyc);
    chk("R2", "zero latency", cyc, 1);
    chk("R2", "zero lambda", lambda_o, 264'h1);
    chk("R2", "zero omega", omega_o, 520'h1);
    chk("R2", "zero len", len_o, 7'd0);
    chk("R2", "zero fail", fail_o, 1'b0);
  endtask

  task automatic t_single();
    int cyc;
    ne = 1; epos[0] = 5; eval[0] = 8'h37;
    calc_syn(); calc_lam(); calc_omg();
    launch_wait(cyc);
    check_full("single", cyc, 1'b0);
  endtask

  task automatic t_tail16();
    int cyc;
    ne = 16;
    for (int e = 0; e < 16; e++) begin
      epos[e] = 239 + e;
      eval[e] = 8'(1 + (e * 13 + 6) % 255);
    end
    calc_syn(); calc_lam(); calc_omg();
    launch_wait(cyc);
    check_full("tail16", cyc, 1'b0);
  endtask

  task automatic t_mid32();
    int cyc;
    ne = 32;
    for (int e = 0; e < 32; e++) begin
      epos[e] = 100 + e;
      eval[e] = 8'(1 + (e * 29) % 255);
    end
    calc_syn(); calc_lam(); calc_omg();
    launch_wait(cyc);
    check_full("mid32 full capacity", cyc, 1'b0);
  endtask

  task automatic t_head8();
    int cyc;
    ne = 8;
    for (int e = 0; e < 8; e++) begin
      epos[e] = e;
      eval[e] = 8'hFF;
    end
    calc_syn(); calc_lam(); calc_omg();
    launch_wait(cyc);
    check_full("head8", cyc, 1'b0);
    // R7: results hold while idle, strobe is a single cycle
    for (int w = 0; w < 4; w++) @(negedge clk);
    chk("R7", "done low after pulse", done_o, 1'b0);
    chk("R7", "lambda held", lambda_o, pack_lam());
    chk("R7", "omega held", omega_o, pack_omg());
  endtask

  // only S_64 nonzero: length jumps to 64, locator stays 1
  task automatic t_fail_late();
    int cyc;
    clear_syn();
    syn[64] = 8'h5A;
    ne = 0; calc_lam(); calc_omg();
    launch_wait(cyc);
    chk("R5", "late fail flag", fail_o, 1'b1);
    chk("R5", "late len", len_o, 7'd64);
    chk("R3", "late lambda", lambda_o, 264'h1);
    chk("R4", "late omega", omega_o, pack_omg());
  endtask

  // only S_1 nonzero: L = 1 but Lambda collapses to degree 0
  task automatic t_fail_deg();
    int cyc;
    clear_syn();
    syn[1] = 8'h9C;
    ne = 0; calc_lam(); calc_omg();
    launch_wait(cyc);
    chk("R5", "degree fail flag", fail_o, 1'b1);
    chk("R5", "degree len", len_o, 7'd1);
    chk("R3", "degree lambda", lambda_o, 264'h1);
    chk("R4", "degree omega", omega_o, pack_omg());
  endtask

  task automatic t_busy_ignore();
    int cyc;
    ne = 3;
    epos[0] = 17; eval[0] = 8'h11;
    epos[1] = 90; eval[1] = 8'hC3;
    epos[2] = 200; eval[2] = 8'h04;
    calc_syn(); calc_lam(); calc_omg();
    @(negedge clk);
    syn_i   = pack_syn();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int w = 0; w < 10; w++) @(negedge clk);
    // second pattern with different syndromes while running
    ne = 1; epos[0] = 3; eval[0] = 8'h77;
    calc_syn();
    syn_i   = pack_syn();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 12;
    while (!done_o && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R6", "busy start done", done_o, 1'b1);
    chk("R6", "busy lambda", lambda_o, pack_lam());
    chk("R6", "busy len", len_o, 7'd3);
    chk("R6", "busy omega", omega_o, pack_omg());
  endtask

  task automatic t_back_to_back();
    int cyc;
    ne = 2;
    epos[0] = 44;  eval[0] = 8'hA5;
    epos[1] = 160; eval[1] = 8'h3E;
    calc_syn(); calc_lam(); calc_omg();
    launch_wait(cyc);
    check_full("b2b first", cyc, 1'b0);
    // start in the done cycle
    syn_i   = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8", "b2b second done", done_o, 1'b1);
    chk("R8", "b2b second lambda", lambda_o, 264'h1);
    chk("R8", "b2b second omega", omega_o, 520'h1);
    chk("R8", "b2b second len", len_o, 7'd0);
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000", tick);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) glog[i] = 0;
    begin
      int v;
      v = 1;
      for (int i = 0; i < 255; i++) begin
        gexp[i] = v;
        glog[v] = i;
        v = v << 1;
        if (v & 256) v = v ^ 32'h11D;
      end
    end
    for (int w = 0; w < 3; w++) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_single();
    t_tail16();
    t_mid32();
    t_head8();
    t_fail_late();
    t_fail_deg();
    t_busy_ignore();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule